// File: doc/BRIEF.md
# Return-Address Integrity Guard

This block keeps a protected copy of return addresses beside a processor's ordinary control flow. Each call event pushes its return address into a small on-chip stack. Each return event pops that stack and compares the popped value with the return address the processor recovered from its own data stack. The transfer is granted only when both copies agree. A disagreement, a push onto a full stack, a pop from an empty stack, or any attempt to write the stack from a source other than a call or return raises a sticky fault instead of silently continuing.

The processor presents call and return strobes with their addresses. It waits for the grant before it commits a return. When checking is switched off, returns are granted without comparison and the stack is left alone, so code runs as it would on a machine without the guard. A fault freezes the stack until a synchronous clear arrives. The current stack depth is visible for debug.

Top module: `retaddr_guard`

## Requirements
- R1: With checking on and no fault, a call without a return in the same cycle, on a stack holding fewer than DEPTH entries, stores call_addr on top and raises depth by one on the next cycle.
- R2: A return whose ret_addr equals the top entry raises ret_grant for exactly one cycle, on the cycle after the return, and lowers depth by one.
- R3: A return whose ret_addr differs from the top entry gives no grant, sets fault with fault_cause 1, and leaves the entry on the stack with depth unchanged.
- R4: A call on a stack already holding DEPTH entries sets fault with fault_cause 3 and leaves depth at DEPTH. Nothing wraps.
- R5: A return on an empty stack sets fault with fault_cause 2, gives no grant, and leaves depth at 0.
- R6: A stray_wr strobe with checking on sets fault with fault_cause 4. The stack contents and depth are unchanged, and any call or return in that cycle is dropped.
- R7: With chk_en low, every return is granted on the next cycle without comparison, calls are not stored, depth is unchanged, and no fault is raised.
- R8: fault stays set, and with checking on, calls and returns are ignored (no grant, no depth change) until fault_clr is asserted. On the cycle after fault_clr, fault is 0 and fault_cause is 0. Events in the clear cycle are ignored.
- R9: A call and a return in the same cycle are handled return first and then call. On a full stack with a matching return, both succeed, depth stays at DEPTH, and the new top is call_addr. On an empty stack, the return underflows and the call is dropped.
- R10: depth never exceeds DEPTH.
- R11: After reset, ret_grant is 0, fault is 0, fault_cause is 0 and depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | 1 enables checking, 0 passes returns through unchecked |
| call_vld | input | 1 | Call event strobe |
| call_addr | input | AW | Return address pushed by the call |
| ret_vld | input | 1 | Return event strobe |
| ret_addr | input | AW | Return address taken from the data stack |
| stray_wr | input | 1 | Write attempt from a source other than call or return |
| fault_clr | input | 1 | Synchronous clear of the sticky fault |
| ret_grant | output | 1 | One-cycle grant for the return of the previous cycle |
| fault | output | 1 | Sticky fault flag |
| fault_cause | output | 3 | 0 none, 1 mismatch, 2 underflow, 3 overflow, 4 stray write |
| depth | output | $clog2(DEPTH+1) | Current number of stored entries |

## Verification
The bench builds the guard with DEPTH 4 and AW 16. The shallow stack reaches the full condition after four calls, so overflow, the return-then-call case on a full stack, and refilling a slot just vacated by a pop all come up within a short vector table. The 16-bit addresses keep the vectors readable while still letting mismatching values differ from the stored top. A mid-run reset is checked after the stack has been filled.

// File: rtl/retaddr_guard_pkg.sv
package retaddr_guard_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_MISMATCH = 3'd1,
        CAUSE_UNDER    = 3'd2,
        CAUSE_OVER     = 3'd3,
        CAUSE_STRAY    = 3'd4
    } cause_e;

endpackage

// File: rtl/retaddr_guard_lifo.sv
module retaddr_guard_lifo #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [IW-1:0] push_idx,
    input  logic [AW-1:0] push_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] top_data
);

    logic [AW-1:0] slot_d [DEPTH];
    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (push_en && (push_idx == IW'(g))) begin
                slot_d[g] = push_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign top_data = slot_q[rd_idx];

    // R1: a push always targets an existing slot
    p_push_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (int'(push_idx) < DEPTH));

    // R1: the pushed word is what the slot holds afterwards
    p_push_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (slot_q[$past(push_idx)] == $past(push_data)));

endmodule

// File: rtl/retaddr_guard_ctrl.sv
module retaddr_guard_ctrl
    import retaddr_guard_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic          call_vld,
    input  logic [AW-1:0] call_addr,
    input  logic          ret_vld,
    input  logic [AW-1:0] ret_addr,
    input  logic          stray_wr,
    input  logic          fault_clr,
    input  logic [AW-1:0] top_data,
    output logic          push_en,
    output logic [IW-1:0] push_idx,
    output logic [AW-1:0] push_data,
    output logic [IW-1:0] rd_idx,
    output logic          grant,
    output logic          fault,
    output cause_e        cause,
    output logic [DW-1:0] depth
);

    typedef struct packed {
        logic          grant;
        logic          fault;
        cause_e        cause;
        logic [DW-1:0] depth;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] depth_m1;
    logic [DW-1:0] after_ret;
    logic          ret_bad;

    assign depth_m1  = st_q.depth - DW'(1);
    assign rd_idx    = depth_m1[IW-1:0];
    assign push_data = call_addr;

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        push_en    = 1'b0;
        push_idx   = '0;
        after_ret  = st_q.depth;
        ret_bad    = 1'b0;

        if (fault_clr) begin
            st_d.fault = 1'b0;
            st_d.cause = CAUSE_NONE;
        end else if (!chk_en) begin
            st_d.grant = ret_vld;
        end else if (st_q.fault) begin
            st_d = st_q;
            st_d.grant = 1'b0;
        end else if (stray_wr) begin
            st_d.fault = 1'b1;
            st_d.cause = CAUSE_STRAY;
        end else begin
            if (ret_vld) begin
                if (st_q.depth == '0) begin
                    st_d.fault = 1'b1;
                    st_d.cause = CAUSE_UNDER;
                    ret_bad    = 1'b1;
                end else if (ret_addr != top_data) begin
                    st_d.fault = 1'b1;
                    st_d.cause = CAUSE_MISMATCH;
                    ret_bad    = 1'b1;
                end else begin
                    st_d.grant = 1'b1;
                    after_ret  = depth_m1;
                end
            end
            if (call_vld && !ret_bad) begin
                if (after_ret == DW'(DEPTH)) begin
                    st_d.fault = 1'b1;
                    st_d.cause = CAUSE_OVER;
                end else begin
                    push_en   = 1'b1;
                    push_idx  = after_ret[IW-1:0];
                    after_ret = after_ret + DW'(1);
                end
            end
            st_d.depth = after_ret;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{grant: 1'b0, fault: 1'b0, cause: CAUSE_NONE, depth: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;
    assign fault = st_q.fault;
    assign cause = st_q.cause;
    assign depth = st_q.depth;

    // R1: accepted lone call grows the stack by one
    p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !fault && !fault_clr && !stray_wr && call_vld && !ret_vld
         && (depth < DW'(DEPTH))) |=> (depth == $past(depth) + DW'(1)));

    // R3: a differing return never yields a grant
    p_mismatch_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !fault && !fault_clr && !stray_wr && ret_vld
         && (depth != '0) && (ret_addr != top_data))
        |=> (fault && !grant && (cause == CAUSE_MISMATCH)));

    // R4: a push on a full stack faults and does not wrap
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !fault && !fault_clr && !stray_wr && call_vld && !ret_vld
         && (depth == DW'(DEPTH))) |=> (fault && (cause == CAUSE_OVER) && (depth == DW'(DEPTH))));

    // R5: a pop on an empty stack faults
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !fault && !fault_clr && !stray_wr && ret_vld && (depth == '0))
        |=> (fault && !grant && (cause == CAUSE_UNDER) && (depth == '0)));

    // R6: stray writes never reach the storage
    p_stray_rejected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !fault && !fault_clr && stray_wr)
        |-> (!push_en ##1 (fault && (cause == CAUSE_STRAY) && $stable(depth))));

    // R7: bypass grants every return and leaves the stack untouched
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_en && !fault_clr) |-> (!push_en ##1 (grant == $past(ret_vld) && $stable(depth))));

    // R8: fault stays until cleared, stack frozen while checking
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> (fault && $stable(depth)));

    // R8: clear takes effect on the next cycle
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> (!fault && (cause == CAUSE_NONE) && !grant));

    // R10: depth bounded by the parameter
    p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH);

endmodule

// File: rtl/retaddr_guard.sv
module retaddr_guard
    import retaddr_guard_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic          call_vld,
    input  logic [AW-1:0] call_addr,
    input  logic          ret_vld,
    input  logic [AW-1:0] ret_addr,
    input  logic          stray_wr,
    input  logic          fault_clr,
    output logic          ret_grant,
    output logic          fault,
    output logic [2:0]    fault_cause,
    output logic [DW-1:0] depth
);

    logic          push_en;
    logic [IW-1:0] push_idx;
    logic [AW-1:0] push_data;
    logic [IW-1:0] rd_idx;
    logic [AW-1:0] top_data;
    cause_e        cause;

    retaddr_guard_lifo #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) i_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_idx  (push_idx),
        .push_data (push_data),
        .rd_idx    (rd_idx),
        .top_data  (top_data)
    );

    retaddr_guard_ctrl #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (chk_en),
        .call_vld  (call_vld),
        .call_addr (call_addr),
        .ret_vld   (ret_vld),
        .ret_addr  (ret_addr),
        .stray_wr  (stray_wr),
        .fault_clr (fault_clr),
        .top_data  (top_data),
        .push_en   (push_en),
        .push_idx  (push_idx),
        .push_data (push_data),
        .rd_idx    (rd_idx),
        .grant     (ret_grant),
        .fault     (fault),
        .cause     (cause),
        .depth     (depth)
    );

    assign fault_cause = cause;

    // R2: a grant only follows a return or bypass in the previous cycle
    p_grant_follows_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_grant |-> $past(ret_vld));

    // R2: a granted checked return shrinks the stack by one
    p_grant_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_grant && $past(chk_en) && !$past(call_vld)) |-> (depth == $past(depth) - DW'(1)));

endmodule

// File: tb/test_retaddr_guard.sv
module test_retaddr_guard;

    localparam int AW    = 16;
    localparam int DEPTH = 4;
    localparam int DW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_en = 1'b0;
    logic          call_vld = 1'b0;
    logic [AW-1:0] call_addr = '0;
    logic          ret_vld = 1'b0;
    logic [AW-1:0] ret_addr = '0;
    logic          stray_wr = 1'b0;
    logic          fault_clr = 1'b0;
    logic          ret_grant;
    logic          fault;
    logic [2:0]    fault_cause;
    logic [DW-1:0] depth;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    retaddr_guard #(.AW(AW), .DEPTH(DEPTH)) i_retaddr_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_en      (chk_en),
        .call_vld    (call_vld),
        .call_addr   (call_addr),
        .ret_vld     (ret_vld),
        .ret_addr    (ret_addr),
        .stray_wr    (stray_wr),
        .fault_clr   (fault_clr),
        .ret_grant   (ret_grant),
        .fault       (fault),
        .fault_cause (fault_cause),
        .depth       (depth)
    );

    typedef struct packed {
        logic       clr;
        logic       en;
        logic       wr;
        logic       call;
        logic       ret;
        logic [15:0] ca;
        logic [15:0] ra;
        logic       g;
        logic       f;
        logic [2:0] cause;
        logic [2:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 26;
    // clr en wr call ret  call_addr ret_addr | grant fault cause depth | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000, 1'b0,1'b0,3'd0,3'd0, 8'd11}, // R11 idle
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h1111,16'h0000, 1'b0,1'b0,3'd0,3'd1, 8'd1},  // R1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h2222,16'h0000, 1'b0,1'b0,3'd0,3'd2, 8'd1},  // R1
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h2222, 1'b1,1'b0,3'd0,3'd1, 8'd2},  // R2
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h3333,16'h0000, 1'b0,1'b0,3'd0,3'd2, 8'd1},  // R1 refill
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h4444,16'h0000, 1'b0,1'b0,3'd0,3'd3, 8'd1},  // R1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h5555,16'h0000, 1'b0,1'b0,3'd0,3'd4, 8'd1},  // R1 full
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h6666,16'h0000, 1'b0,1'b1,3'd3,3'd4, 8'd4},  // R4 overflow
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h7777,16'h0000, 1'b0,1'b1,3'd3,3'd4, 8'd8},  // R8 call ignored
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h5555, 1'b0,1'b1,3'd3,3'd4, 8'd8},  // R8 ret ignored
        '{1'b1,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h5555, 1'b0,1'b0,3'd0,3'd4, 8'd8},  // R8 clear
        '{1'b0,1'b1,1'b0,1'b1,1'b1,16'h8888,16'h5555, 1'b1,1'b0,3'd0,3'd4, 8'd9},  // R9 full
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h8888, 1'b1,1'b0,3'd0,3'd3, 8'd9},  // R9 new top
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h9999, 1'b0,1'b1,3'd1,3'd3, 8'd3},  // R3 mismatch
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000, 1'b0,1'b0,3'd0,3'd3, 8'd8},  // R8 clear
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h4444, 1'b1,1'b0,3'd0,3'd2, 8'd3},  // R3 entry kept
        '{1'b0,1'b1,1'b1,1'b1,1'b0,16'hAAAA,16'h0000, 1'b0,1'b1,3'd4,3'd2, 8'd6},  // R6 stray
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000, 1'b0,1'b0,3'd0,3'd2, 8'd8},  // R8 clear
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h3333, 1'b1,1'b0,3'd0,3'd1, 8'd6},  // R6 contents intact
        '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1234, 1'b1,1'b0,3'd0,3'd1, 8'd7},  // R7 bypass ret
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h5678,16'h0000, 1'b0,1'b0,3'd0,3'd1, 8'd7},  // R7 bypass call
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1111, 1'b1,1'b0,3'd0,3'd0, 8'd2},  // R2 last pop
        '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1111, 1'b0,1'b1,3'd2,3'd0, 8'd5},  // R5 underflow
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000, 1'b0,1'b0,3'd0,3'd0, 8'd8},  // R8 clear
        '{1'b0,1'b1,1'b0,1'b1,1'b1,16'h0002,16'h0001, 1'b0,1'b1,3'd2,3'd0, 8'd9},  // R9 empty
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000, 1'b0,1'b0,3'd0,3'd0, 8'd8}   // R8 clear
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    task automatic drive(input vec_t v);
        fault_clr = v.clr;
        chk_en    = v.en;
        stray_wr  = v.wr;
        call_vld  = v.call;
        ret_vld   = v.ret;
        call_addr = v.ca;
        ret_addr  = v.ra;
    endtask

    task automatic idle();
        fault_clr = 1'b0;
        stray_wr  = 1'b0;
        call_vld  = 1'b0;
        ret_vld   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "grant in reset", int'(ret_grant), 0);
        check("R11", "fault in reset", int'(fault), 0);
        check("R11", "cause in reset", int'(fault_cause), 0);
        check("R11", "depth in reset", int'(depth), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VECS[i]);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check(tag, "grant", int'(ret_grant), int'(VECS[i].g));
            check(tag, "fault", int'(fault), int'(VECS[i].f));
            check(tag, "cause", int'(fault_cause), int'(VECS[i].cause));
            check(tag, "depth", int'(depth), int'(VECS[i].d));
        end
        idle();

        // R2: grant lasts exactly one cycle
        chk_en = 1'b1;
        call_vld = 1'b1; call_addr = 16'hBEEF;
        @(negedge clk);
        call_vld = 1'b0; ret_vld = 1'b1; ret_addr = 16'hBEEF;
        @(negedge clk);
        ret_vld = 1'b0;
        check("R2", "grant pulse", int'(ret_grant), 1);
        @(negedge clk);
        check("R2", "grant drops", int'(ret_grant), 0);

        // R10: many calls on a full stack keep depth at DEPTH
        for (int k = 0; k < DEPTH + 3; k++) begin
            call_vld = 1'b1; call_addr = AW'(16'hC000 + k);
            @(negedge clk);
        end
        call_vld = 1'b0;
        check("R10", "depth capped", int'(depth), DEPTH);
        check("R4", "overflow cause", int'(fault_cause), 3);

        // R11: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "depth after reset", int'(depth), 0);
        check("R11", "fault after reset", int'(fault), 0);
        check("R11", "cause after reset", int'(fault_cause), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ret_vld = 1'b1; ret_addr = 16'hC003;
        @(negedge clk);
        ret_vld = 1'b0;
        check("R5", "underflow after reset", int'(fault_cause), 2);

        summary();
        $finish;
    end

endmodule